// File: doc/BRIEF.md
# Two-Wire Bus Slave Front End

This block sits between an open-drain two-wire serial bus and the memory engine of a small serial storage device. It samples the clock line and the data line with a fast system clock. From those samples it finds start and stop conditions and assembles incoming bits into bytes. It also pulls the data line low wherever the protocol needs a zero from the slave: the acknowledge slot, and the zero bits of a read byte.

The first byte after a start is a device-address byte. The block acknowledges it only if the upper nibble carries the fixed family code and the next three bits equal the strap pins. When it acknowledges, it reports whether a read or a write was requested. During a write it hands each received byte to the engine, and the engine decides whether that byte is acknowledged. During a read it fetches a transmit byte from the engine, shifts it out, and samples the master's acknowledge to decide whether to fetch another byte.

Top module: `twb_slave_front`

## Requirements
- R1: While reset is high and after it is released, `sda_pull` is low and no event pulse is raised until bus activity occurs.
- R2: The block pulses `evt_start` once when the data line falls while the clock line stays high, and `evt_stop` once when the data line rises while the clock line stays high. A data-line change that lands in the same synchronized sample as a clock-line rise is taken as a data bit, not as a condition.
- R3: After a start, the first byte is taken MSB first on clock rising edges. If bits 7..4 are 1010 and bits 3..1 equal `strap_id[2:0]`, the block pulses `addr_hit`, sets `rw_bit` to bit 0 (1 = read), and holds the data line low for the ninth clock.
- R4: On an address mismatch, in either the family nibble or the strap bits, the block does not acknowledge. It then ignores all bus traffic until the next start: no acknowledge, no `rx_valid`.
- R5: In a write, each received byte is presented on `rx_byte` with a one-cycle `rx_valid` pulse after its eighth rising clock edge. The block acknowledges the byte in the ninth clock if `ack_en` is high at the clock fall that ends the eighth bit. If `ack_en` is low, it does not acknowledge and ignores bytes until the next start.
- R6: In a read, `tx_byte` is latched with a `tx_req` pulse at the clock fall that ends the address acknowledge. It is then sent MSB first, with each bit changing only after a clock fall, and the data line is released in the ninth clock.
- R7: A low data line in the ninth clock of a read byte (master acknowledge) makes the block latch and send the next `tx_byte` with a new `tx_req`. A high data line there (no acknowledge) makes the block stop driving and issue no `tx_req` until a new start.
- R8: A start that arrives in the middle of a transaction, with no stop before it, restarts device-address reception.
- R9: A stop releases the data line and returns the block to standby, where clocked bytes are ignored until a start.
- R10: `sda_pull` changes only right after a synchronized clock fall, or when a start or stop is detected; it never changes while the clock line is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level (wired-AND of all drivers) |
| strap_id | input | 3 | Pin-strapped low address bits |
| sda_pull | output | 1 | 1 pulls the data line low; 0 releases it |
| evt_start | output | 1 | One-cycle pulse on a start or repeated start |
| evt_stop | output | 1 | One-cycle pulse on a stop |
| addr_hit | output | 1 | One-cycle pulse when the address byte matches |
| rw_bit | output | 1 | Direction of the last matched address, 1 = read |
| rx_valid | output | 1 | One-cycle pulse when a write data byte is complete |
| rx_byte | output | 8 | Received data byte, valid with `rx_valid` |
| ack_en | input | 1 | Engine allows acknowledging the current write byte |
| tx_byte | input | 8 | Next byte to send in a read |
| tx_req | output | 1 | One-cycle pulse when `tx_byte` has been latched |

## Verification
A master can move the data line in the same system-clock sample in which the clock line rises. The condition detector and the bit shifter then both see an edge in that one cycle. The bench provokes this by clocking a whole write byte in which every data level is applied together with the clock rise. It judges the outcome by requiring that the received byte equals the bits sent and that neither the start count nor the stop count moves.

// File: rtl/twb_pkg.sv
package twb_pkg;

    localparam int BYTE_W    = 8;
    localparam int CNT_W     = $clog2(BYTE_W + 1);
    localparam int LINES     = 2;
    localparam int IDX_SDA   = 0;
    localparam int IDX_SCL   = 1;
    localparam logic [3:0] DEV_FAMILY = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK
    } twb_state_t;

    typedef struct packed {
        logic lvl;
        logic prev;
        logic rise;
        logic fall;
    } line_view_t;

    function automatic logic dev_match(input logic [BYTE_W-1:0] b,
                                       input logic [2:0]        strap);
        return (b[7:4] == DEV_FAMILY) && (b[3:1] == strap);
    endfunction

endpackage

// File: rtl/twb_line_sync.sv
module twb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output twb_pkg::line_view_t view
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            last  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            last  <= chain[STAGES-1];
        end
    end

    always_comb begin
        view.lvl  = chain[STAGES-1];
        view.prev = last;
        view.rise = chain[STAGES-1] & ~last;
        view.fall = ~chain[STAGES-1] & last;
    end
endmodule

// File: rtl/twb_cond_det.sv
module twb_cond_det (
    input  twb_pkg::line_view_t scl_v,
    input  twb_pkg::line_view_t sda_v,
    output logic                start_det,
    output logic                stop_det
);
    logic scl_steady_high;

    always_comb begin
        scl_steady_high = scl_v.lvl & scl_v.prev;
        start_det       = scl_steady_high & sda_v.fall;
        stop_det        = scl_steady_high & sda_v.rise;
    end
endmodule

// File: rtl/twb_ctrl.sv
module twb_ctrl
    import twb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [2:0]        strap_id,
    input  logic              ack_en,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              sda_pull,
    output logic              evt_start,
    output logic              evt_stop,
    output logic              addr_hit,
    output logic              rw_bit,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              tx_req
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

    twb_state_t        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              mst_ack;

    assign rx_byte = shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            mst_ack   <= 1'b0;
            sda_pull  <= 1'b0;
            rw_bit    <= 1'b0;
            evt_start <= 1'b0;
            evt_stop  <= 1'b0;
            addr_hit  <= 1'b0;
            rx_valid  <= 1'b0;
            tx_req    <= 1'b0;
        end else begin
            evt_start <= start_det;
            evt_stop  <= stop_det;
            addr_hit  <= 1'b0;
            rx_valid  <= 1'b0;
            tx_req    <= 1'b0;
            if (start_det) begin
                state    <= ST_ADDR;
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
            end else if (stop_det) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_WDATA: begin
                        if (scl_rise && bit_cnt != FULL) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == LAST_BIT && state == ST_WDATA)
                                rx_valid <= 1'b1;
                        end else if (scl_fall && bit_cnt == FULL) begin
                            if (state == ST_ADDR) begin
                                if (dev_match(shreg, strap_id)) begin
                                    sda_pull <= 1'b1;
                                    addr_hit <= 1'b1;
                                    rw_bit   <= shreg[0];
                                    state    <= ST_AACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (ack_en) begin
                                sda_pull <= 1'b1;
                                state    <= ST_WACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_AACK, ST_RACK: begin
                        if (scl_rise && state == ST_RACK) begin
                            mst_ack <= ~sda_lvl;
                        end else if (scl_fall) begin
                            bit_cnt <= '0;
                            if (state == ST_AACK && !rw_bit) begin
                                sda_pull <= 1'b0;
                                state    <= ST_WDATA;
                            end else if (state == ST_AACK || mst_ack) begin
                                shreg    <= tx_byte;
                                sda_pull <= ~tx_byte[BYTE_W-1];
                                tx_req   <= 1'b1;
                                state    <= ST_RDATA;
                            end else begin
                                sda_pull <= 1'b0;
                                state    <= ST_IDLE;
                            end
                        end
                    end
                    ST_WACK: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b0;
                            bit_cnt  <= '0;
                            state    <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise && bit_cnt != FULL) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (bit_cnt == FULL) begin
                                sda_pull <= 1'b0;
                                state    <= ST_RACK;
                            end else begin
                                shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_pull <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    default: begin
                        sda_pull <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/twb_slave_front.sv
module twb_slave_front
    import twb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [2:0]        strap_id,
    output logic              sda_pull,
    output logic              evt_start,
    output logic              evt_stop,
    output logic              addr_hit,
    output logic              rw_bit,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    input  logic              ack_en,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              tx_req
);
    logic [LINES-1:0] raw;
    line_view_t       views [LINES];
    logic             start_det;
    logic             stop_det;
    logic             scl_fall;
    logic             scl_lvl;

    assign raw[IDX_SDA] = sda_in;
    assign raw[IDX_SCL] = scl_in;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        twb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (raw[g]),
            .view (views[g])
        );
    end

    assign scl_fall = views[IDX_SCL].fall;
    assign scl_lvl  = views[IDX_SCL].lvl;

    twb_cond_det u_cond (
        .scl_v     (views[IDX_SCL]),
        .sda_v     (views[IDX_SDA]),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twb_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .scl_rise  (views[IDX_SCL].rise),
        .scl_fall  (scl_fall),
        .sda_lvl   (views[IDX_SDA].lvl),
        .start_det (start_det),
        .stop_det  (stop_det),
        .strap_id  (strap_id),
        .ack_en    (ack_en),
        .tx_byte   (tx_byte),
        .sda_pull  (sda_pull),
        .evt_start (evt_start),
        .evt_stop  (evt_stop),
        .addr_hit  (addr_hit),
        .rw_bit    (rw_bit),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .tx_req    (tx_req)
    );
endmodule

// File: rtl/twb_slave_front_chk.sv
module twb_slave_front_chk (
    input logic clk,
    input logic rst,
    input logic sda_pull,
    input logic evt_start,
    input logic evt_stop,
    input logic addr_hit,
    input logic rx_valid,
    input logic tx_req,
    input logic scl_fall,
    input logic scl_lvl,
    input logic start_det,
    input logic stop_det
);
    AST_PULL_SET_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> $past(scl_fall)); // R10

    AST_PULL_CLEAR_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_pull) |-> $past(scl_fall || start_det || stop_det)); // R10

    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt_start, evt_stop, addr_hit, rx_valid, tx_req})); // R2

    AST_START_WITH_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        evt_start |-> $past(scl_lvl)); // R2

    AST_HIT_PULLS_ACK: assert property (@(posedge clk) disable iff (rst)
        addr_hit |-> sda_pull); // R3

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
        evt_stop |-> !sda_pull); // R9

    AST_TXREQ_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        tx_req |-> $past(scl_fall)); // R6
endmodule

bind twb_slave_front twb_slave_front_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sda_pull  (sda_pull),
    .evt_start (evt_start),
    .evt_stop  (evt_stop),
    .addr_hit  (addr_hit),
    .rx_valid  (rx_valid),
    .tx_req    (tx_req),
    .scl_fall  (scl_fall),
    .scl_lvl   (scl_lvl),
    .start_det (start_det),
    .stop_det  (stop_det)
);

// File: tb/tb_twb_slave_front.sv
`timescale 1ns/1ps
module tb_twb_slave_front;
    localparam int H = 8;
    localparam logic [2:0] STRAP = 3'b101;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       ack_en = 1'b1;
    logic       sda_pull, evt_start, evt_stop, addr_hit, rw_bit, rx_valid, tx_req;
    logic [7:0] rx_byte, tx_byte;
    logic       sda_line;

    int n_chk = 0, n_fail = 0;
    int n_start = 0, n_stop = 0, n_hit = 0, n_rx = 0, n_txreq = 0, n_bad_pull = 0;
    logic [7:0] last_rx = 8'h00;
    logic       prev_pull = 1'b0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    assign sda_line = m_sda & ~sda_pull;

    function automatic logic [7:0] rd_seq(input int k);
        return 8'hC3 + 8'(k * 37);
    endfunction
    assign tx_byte = rd_seq(n_txreq);

    twb_slave_front dut (
        .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_line), .strap_id(STRAP),
        .sda_pull(sda_pull), .evt_start(evt_start), .evt_stop(evt_stop),
        .addr_hit(addr_hit), .rw_bit(rw_bit), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .ack_en(ack_en), .tx_byte(tx_byte), .tx_req(tx_req)
    );

    always @(negedge clk) begin
        if (!rst) begin
            n_start <= n_start + int'(evt_start);
            n_stop  <= n_stop + int'(evt_stop);
            n_hit   <= n_hit + int'(addr_hit);
            n_txreq <= n_txreq + int'(tx_req);
            if (rx_valid) begin
                n_rx    <= n_rx + 1;
                last_rx <= rx_byte;
            end
            if (sda_pull != prev_pull && m_scl) n_bad_pull <= n_bad_pull + 1;
            prev_pull <= sda_pull;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hold(H);
        m_scl = 1'b1; hold(H);
        m_sda = 1'b0; hold(H);
        m_scl = 1'b0; hold(H);
    endtask

    task automatic bus_stop();
        m_scl = 1'b0; hold(H);
        m_sda = 1'b0; hold(H);
        m_scl = 1'b1; hold(H);
        m_sda = 1'b1; hold(2 * H);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit race, output bit acked);
        m_scl = 1'b0; hold(H);
        for (int i = 7; i >= 0; i--) begin
            if (race) begin
                m_sda = b[i]; m_scl = 1'b1;
            end else begin
                m_sda = b[i]; hold(H);
                m_scl = 1'b1;
            end
            hold(2 * H);
            m_scl = 1'b0; hold(H);
        end
        m_sda = 1'b1; hold(H);
        m_scl = 1'b1; hold(H);
        acked = (sda_line == 1'b0);
        hold(H);
        m_scl = 1'b0; hold(H);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hold(H);
            m_scl = 1'b1; hold(H);
            b[i] = sda_line;
            hold(H);
            m_scl = 1'b0;
        end
        hold(H);
        m_sda = mack ? 1'b0 : 1'b1; hold(H);
        m_scl = 1'b1; hold(2 * H);
        m_scl = 1'b0; hold(H);
        m_sda = 1'b1; hold(H);
    endtask

    task automatic t_reset();
        chk(sda_pull == 1'b0, "R1", "pull after reset", sda_pull, 0);
        chk(n_start + n_stop + n_hit + n_rx + n_txreq == 0, "R1", "pulses after reset",
            n_start + n_stop + n_hit + n_rx + n_txreq, 0);
    endtask

    task automatic t_write();
        bit a; int s0 = n_start, h0 = n_hit, r0 = n_rx, p0 = n_stop;
        ack_en = 1'b1;
        bus_start();
        chk(n_start == s0 + 1, "R2", "start pulse", n_start, s0 + 1);
        send_byte({4'b1010, STRAP, 1'b0}, 1'b0, a);
        chk(a && n_hit == h0 + 1 && rw_bit == 1'b0, "R3", "address ack/hit/rw",
            {a, n_hit[3:0], rw_bit}, {1'b1, 4'(h0 + 1), 1'b0});
        send_byte(8'hA5, 1'b0, a);
        chk(a && n_rx == r0 + 1 && last_rx == 8'hA5, "R5", "first data byte", last_rx, 8'hA5);
        send_byte(8'h3C, 1'b0, a);
        chk(a && n_rx == r0 + 2 && last_rx == 8'h3C, "R5", "second data byte", last_rx, 8'h3C);
        bus_stop();
        chk(n_stop == p0 + 1, "R2", "stop pulse", n_stop, p0 + 1);
        chk(sda_pull == 1'b0, "R9", "released after stop", sda_pull, 0);
    endtask

    task automatic t_mismatch(input logic [7:0] addr);
        bit a; int h0 = n_hit, r0 = n_rx;
        bus_start();
        send_byte(addr, 1'b0, a);
        chk(!a && n_hit == h0, "R4", "no ack on mismatch", a, 0);
        send_byte(8'h11, 1'b0, a);
        chk(!a && n_rx == r0, "R4", "data ignored after mismatch", n_rx, r0);
        bus_stop();
    endtask

    task automatic t_read();
        bit a; logic [7:0] got; logic [7:0] exp0, exp1; int q0;
        bus_start();
        q0 = n_txreq;
        exp0 = rd_seq(q0);
        exp1 = rd_seq(q0 + 1);
        send_byte({4'b1010, STRAP, 1'b1}, 1'b0, a);
        chk(a && rw_bit == 1'b1, "R3", "read address ack", rw_bit, 1);
        chk(n_txreq == q0 + 1, "R6", "tx_req after address", n_txreq, q0 + 1);
        recv_byte(1'b1, got);
        chk(got == exp0, "R6", "first read byte", got, exp0);
        chk(n_txreq == q0 + 2, "R7", "master ack fetches next", n_txreq, q0 + 2);
        recv_byte(1'b0, got);
        chk(got == exp1, "R7", "second read byte", got, exp1);
        chk(sda_pull == 1'b0 && n_txreq == q0 + 2, "R7", "nack stops sending",
            n_txreq, q0 + 2);
        recv_byte(1'b0, got);
        chk(got == 8'hFF && n_txreq == q0 + 2, "R7", "line released after nack", got, 8'hFF);
        bus_stop();
    endtask

    task automatic t_restart();
        bit a; int h0 = n_hit;
        bus_start();
        send_byte({4'b1010, STRAP, 1'b0}, 1'b0, a);
        send_byte(8'h07, 1'b0, a);
        bus_start();
        send_byte({4'b1010, STRAP, 1'b1}, 1'b0, a);
        chk(a && n_hit == h0 + 2 && rw_bit == 1'b1, "R8", "repeated start readdress",
            n_hit, h0 + 2);
        recv_byte(1'b0, ignore_b);
        bus_stop();
    endtask

    logic [7:0] ignore_b;

    task automatic t_standby();
        bit a; int h0 = n_hit;
        send_byte({4'b1010, STRAP, 1'b0}, 1'b0, a);
        chk(!a && n_hit == h0, "R9", "no address without start", n_hit, h0);
        m_scl = 1'b1; hold(2 * H);
    endtask

    task automatic t_engine_nack();
        bit a; int r0;
        bus_start();
        send_byte({4'b1010, STRAP, 1'b0}, 1'b0, a);
        ack_en = 1'b0;
        r0 = n_rx;
        send_byte(8'h99, 1'b0, a);
        chk(!a && n_rx == r0 + 1, "R5", "engine refuses byte", a, 0);
        ack_en = 1'b1;
        send_byte(8'h66, 1'b0, a);
        chk(!a && n_rx == r0 + 1, "R5", "bytes ignored after refusal", n_rx, r0 + 1);
        bus_stop();
    endtask

    task automatic t_race();
        bit a; int s0, p0;
        bus_start();
        send_byte({4'b1010, STRAP, 1'b0}, 1'b0, a);
        s0 = n_start; p0 = n_stop;
        send_byte(8'h96, 1'b1, a);
        chk(last_rx == 8'h96, "R2", "data with coincident clock edge", last_rx, 8'h96);
        chk(n_start == s0 && n_stop == p0, "R2", "no condition on coincident edge",
            n_start + n_stop, s0 + p0);
        bus_stop();
    endtask

    initial begin
        hold(5);
        rst = 1'b0;
        hold(5);
        t_reset();
        t_write();
        t_mismatch({4'b1010, 3'b100, 1'b0});
        t_mismatch({4'b1011, STRAP, 1'b0});
        t_read();
        t_restart();
        t_standby();
        t_engine_nack();
        t_race();
        chk(n_bad_pull == 0, "R10", "pull changed while clock high", n_bad_pull, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule